// File: doc/BRIEF.md
# Serial LCD Segment Data Loader

This block receives display data for a segment LCD over a three-wire serial link: a serial clock, a data line and an enable. While enable is high, each rising serial-clock edge pushes one data bit into a chain built from up to three 32-bit banks. The chain length follows the multiplex mode. Static mode uses one bank, duplex uses two and triplex uses all three. The last bit of the active chain drives a serial output, so several devices can be daisy-chained.

A 96-bit display register drives the segment outputs as plain logic bits. It does not copy the chain when a transfer ends. It copies only on a frame event, which is made by dividing the system clock. The copy happens only while enable is low. A refresh therefore lands up to half a frame after enable drops, and a transfer in progress never disturbs the shown pattern. The frame phase output toggles on each frame event, so its period is twice the divider length.

All inputs are synchronous to `clk`. The serial clock is edge-detected in the `clk` domain, so it must stay high for at least one `clk` cycle and low for at least one `clk` cycle.

Top module: `seg_serial_loader`

## Requirements
- R1: While `rst` is high, on each clock edge the block clears `seg_bits`, `frame_phase`, `ser_out` and the whole shift chain to 0.
- R2: When `ser_en` is high and `ser_clk` is seen rising (high now, low on the previous `clk` cycle), `ser_dat` enters chain position 0. Every other position takes the value of the position below it. Positions 0-31 form bank A, 32-63 bank B and 64-95 bank C.
- R3: When `ser_en` is low, rising edges of `ser_clk` are ignored. The chain, `ser_out` and any later display load are unchanged by them.
- R4: `ser_out` shows the last bit of the active chain. This is position 31 for `mode` 01 (static) and 00 (also treated as static), position 63 for `mode` 10 (duplex) and position 95 for `mode` 11 (triplex).
- R5: `frame_phase` toggles once every `HALF_FRAME` clock cycles (default 1200), which gives a frame of 2×`HALF_FRAME` cycles.
- R6: While `ser_en` is high, `seg_bits` keeps its value, including across frame events.
- R7: `seg_bits` changes only on the clock edge where `frame_phase` toggles. On that edge, if `ser_en` is low, `seg_bits[i]` takes chain position i for every active position.
- R8: On such a load, bits outside the active chain are written 0. In static mode these are bits 95:32, and in duplex mode bits 95:64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oscillator) |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Drive mode: 00/01 static, 10 duplex, 11 triplex |
| ser_clk | input | 1 | Serial clock, sampled by `clk` |
| ser_dat | input | 1 | Serial data |
| ser_en | input | 1 | Transfer enable, active high |
| ser_out | output | 1 | Cascade output, last bit of the active chain |
| frame_phase | output | 1 | Divided frame clock |
| seg_bits | output | 96 | Segment states, 1 = segment on |

## Verification
The bound checker verifies several properties on every cycle. It checks that the display holds while enable is high, and that the display changes only on a frame event. It checks that idle serial-clock activity leaves the cascade output still, that bits outside the active chain are written 0 in static and duplex modes, and that reset clears everything. Some behaviour can only be shown by the bench's scenarios. These are the bit order through the banks, the cascade output delay of 32, 64 or 96 shifts, the exact divider period, and that ignored edges leave no trace in a later load. The bench shows them by shifting random and directed patterns in every mode and comparing the results with a reference chain.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

  typedef enum logic [1:0] {
    DRV_STATIC_ALT = 2'b00,
    DRV_STATIC     = 2'b01,
    DRV_DUPLEX     = 2'b10,
    DRV_TRIPLEX    = 2'b11
  } drv_mode_e;

  // number of active 32-bit banks for a drive mode
  function automatic logic [1:0] banks_for(input logic [1:0] m);
    case (drv_mode_e'(m))
      DRV_TRIPLEX: return 2'd3;
      DRV_DUPLEX:  return 2'd2;
      default:     return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/lcd_frame_div.sv
module lcd_frame_div #(
  parameter int HALF_FRAME = 1200
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic phase
);
  localparam int CNT_W = (HALF_FRAME > 1) ? $clog2(HALF_FRAME) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_FRAME - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_shift_bank.sv
module lcd_shift_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              din,
  output logic [BANK_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (step) q <= {q[BANK_W-2:0], din};
  end
endmodule

// File: rtl/lcd_disp_latch.sv
module lcd_disp_latch #(
  parameter int BANK_W = 32,
  parameter int BANKS  = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load,
  input  logic [1:0]                   nbanks,
  input  logic [BANKS-1:0][BANK_W-1:0] chain,
  output logic [BANKS-1:0][BANK_W-1:0] seg
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        seg[b] <= '0;
      else if (load)
        seg[b] <= (b < int'(nbanks)) ? chain[b] : '0;
    end
  end
endmodule

// File: rtl/seg_serial_loader.sv
module seg_serial_loader #(
  parameter int BANK_W     = 32,
  parameter int HALF_FRAME = 1200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_en,
  output logic              ser_out,
  output logic              frame_phase,
  output logic [3*BANK_W-1:0] seg_bits
);
  import lcd_seg_pkg::*;

  localparam int BANKS = 3;

  logic                         sclk_q;
  logic                         step;
  logic                         frame_tick;
  logic [1:0]                   nbanks;
  logic [BANKS-1:0][BANK_W-1:0] chain;
  logic [BANKS-1:0][BANK_W-1:0] seg_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= ser_clk;
  end

  assign step   = ser_en & ser_clk & ~sclk_q;
  assign nbanks = banks_for(mode);

  for (genvar b = 0; b < BANKS; b++) begin : g_chain
    logic din_b;
    if (b == 0) begin : g_head
      assign din_b = ser_dat;
    end else begin : g_link
      assign din_b = chain[b-1][BANK_W-1];
    end
    lcd_shift_bank #(.BANK_W(BANK_W)) u_bank (
      .clk (clk),
      .rst (rst),
      .step(step),
      .din (din_b),
      .q   (chain[b])
    );
  end

  always_comb begin
    case (nbanks)
      2'd3:    ser_out = chain[2][BANK_W-1];
      2'd2:    ser_out = chain[1][BANK_W-1];
      default: ser_out = chain[0][BANK_W-1];
    endcase
  end

  lcd_frame_div #(.HALF_FRAME(HALF_FRAME)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (frame_tick),
    .phase(frame_phase)
  );

  lcd_disp_latch #(.BANK_W(BANK_W), .BANKS(BANKS)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .load  (frame_tick & ~ser_en),
    .nbanks(nbanks),
    .chain (chain),
    .seg   (seg_q)
  );

  assign seg_bits = seg_q;
endmodule

// File: rtl/seg_serial_loader_chk.sv
module seg_serial_loader_chk #(
  parameter int BANK_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          mode,
  input logic                ser_en,
  input logic                ser_out,
  input logic                frame_phase,
  input logic [3*BANK_W-1:0] seg_bits,
  input logic                tick
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (seg_bits == '0 && !frame_phase && !ser_out));                        // R1

  AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (rst)
    !ser_en |=> ($stable(ser_out) || !$stable(mode)));                            // R3

  AST_PHASE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(frame_phase));                                              // R5

  AST_HOLD_WHILE_EN: assert property (@(posedge clk) disable iff (rst)
    ser_en |=> $stable(seg_bits));                                                // R6

  AST_NO_LOAD_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(seg_bits));                                                 // R7

  AST_STATIC_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && !ser_en && !mode[1]) |=> (seg_bits[3*BANK_W-1:BANK_W] == '0));       // R8

  AST_DUPLEX_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && !ser_en && mode == 2'b10) |=> (seg_bits[3*BANK_W-1:2*BANK_W] == '0)); // R8
endmodule

bind seg_serial_loader seg_serial_loader_chk #(.BANK_W(BANK_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .mode       (mode),
  .ser_en     (ser_en),
  .ser_out    (ser_out),
  .frame_phase(frame_phase),
  .seg_bits   (seg_bits),
  .tick       (frame_tick)
);

// File: tb/seg_serial_loader_tb_top.sv
module seg_serial_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 1200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b11;
  logic        ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
  logic        ser_out, frame_phase;
  logic [95:0] seg_bits;

  int total = 0, bad = 0;
  logic [95:0] mdl = '0;
  logic [95:0] shown = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_serial_loader dut_i (
    .clk(clk), .rst(rst), .mode(mode), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_en(ser_en), .ser_out(ser_out), .frame_phase(frame_phase), .seg_bits(seg_bits)
  );

  function automatic int chain_len(input logic [1:0] m);
    return (m == 2'b11) ? 96 : (m == 2'b10) ? 64 : 32;
  endfunction

  function automatic logic [95:0] mask_for(input logic [1:0] m);
    return (m == 2'b11) ? {96{1'b1}} : (m == 2'b10) ? {32'h0, {64{1'b1}}} : {64'h0, {32{1'b1}}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one serial clock pulse; returns after the shifting edge
  task automatic pulse(input logic b);
    @(negedge clk); ser_dat = b; ser_clk = 1'b1;
    @(negedge clk); ser_clk = 1'b0;
    if (ser_en) mdl = {mdl[94:0], b};
  endtask

  // wait for a frame event; check display held before it
  task automatic wait_event(input string req);
    logic ph = frame_phase;
    bit held = 1;
    forever begin
      @(negedge clk);
      if (frame_phase != ph) break;
      if (seg_bits != shown) held = 0;
    end
    chk(held, req, seg_bits, shown);
  endtask

  task automatic run_mode(input logic [1:0] m, input int kind);
    int n = chain_len(m);
    logic b;
    logic so;
    mode = m;
    ser_en = 1'b1;
    for (int i = 0; i < n + 8; i++) begin
      case (kind)
        0: b = 1'($urandom);
        1: b = 1'(i & 1);
        2: b = 1'b1;
        default: b = 1'b0;
      endcase
      pulse(b);
      // R2 R4: cascade output is the last active bit of the reference chain
      chk(ser_out == mdl[n-1], "R2/R4 ser_out tap", {95'h0, ser_out}, {95'h0, mdl[n-1]});
    end
    wait_event("R6 hold while enabled");
    chk(seg_bits == shown, "R6 no load with enable high", seg_bits, shown);
    @(negedge clk); ser_en = 1'b0;
    wait_event("R7 no change before frame event");
    shown = mdl & mask_for(m);
    chk(seg_bits == shown, "R7/R8 load on frame event", seg_bits, shown);
    // R3: edges with enable low are ignored
    so = ser_out;
    for (int i = 0; i < 6; i++) begin
      pulse(~mdl[i]);
      chk(ser_out == so, "R3 ignored ser_clk", {95'h0, ser_out}, {95'h0, so});
    end
    wait_event("R3 hold before reload");
    chk(seg_bits == shown, "R3 reload unchanged", seg_bits, shown);
  endtask

  initial begin
    int cnt;
    logic ph;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(seg_bits == '0, "R1 seg_bits reset", seg_bits, '0);
    chk(!frame_phase && !ser_out, "R1 phase/out reset", {94'h0, frame_phase, ser_out}, '0);
    // R5: frame event spacing
    for (int k = 0; k < 2; k++) begin
      ph = frame_phase;
      while (frame_phase == ph) @(negedge clk);
      cnt = 0; ph = frame_phase;
      while (frame_phase == ph) begin @(negedge clk); cnt++; end
      chk(cnt == HALF, "R5 half-frame period", 96'(cnt), 96'(HALF));
    end
    run_mode(2'b01, 0);
    run_mode(2'b10, 1);
    run_mode(2'b11, 0);
    run_mode(2'b00, 2);
    run_mode(2'b11, 3);
    run_mode(2'b10, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule